// File: doc/BRIEF.md
# Track Signal Bit Decoder

This block recovers data bits from a digitised model-railway track waveform. The waveform carries each bit as two half-periods, one on each side of a level change. A short half means a one and a long half means a zero. The block brings the raw track level into its clock domain and finds each level change. It counts microsecond ticks between consecutive changes and sorts every measured half into one of three classes: short, long, or out of tolerance.

Two consecutive halves of the same class form one bit. The result is delivered as a one-clock strobe with the bit value alongside it. Timing that violates the windows is reported on a separate one-clock error strobe. A pair with mismatched classes is also an error, and in that case the second half is kept as the start of the next bit. Framing, preamble detection and checksums belong to the logic downstream.

Top module: `track_bit_decoder`

## Requirements
- R1: While rst_ni is low, and after it is released, bit_valid_o, bit_o and err_o are 0 until a measured half produces a result.
- R2: Rising and falling levels of track_i are both half boundaries. The level passes two synchroniser flops, and a result strobe appears exactly two clocks after the clock on which the synchronised level changes.
- R3: A half lasting 52 to 64 ticks inclusive is a short half (one-class).
- R4: A half lasting 90 to 10000 ticks inclusive is a long half (zero-class).
- R5: Two consecutive halves of the same class raise bit_valid_o for one clock. bit_o is 1 for two short halves and 0 for two long halves, and it holds its value between strobes.
- R6: A half outside both windows (below 52, 65 to 89, or above 10000 ticks) raises err_o for one clock and discards any pending first half.
- R7: A second half whose class differs from the first raises err_o for one clock, and that second half becomes the first half of the next bit.
- R8: The tick counter saturates above 10000. A line held steady for any length of time yields exactly one err_o, at the level change that ends it.
- R9: The first level change after reset only starts timing and produces no strobe.
- R10: bit_valid_o and err_o are never high in the same clock, and bit_valid_o is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| track_i | input | 1 | Digitised track level, asynchronous |
| tick_us_i | input | 1 | One-clock pulse per microsecond |
| bit_valid_o | output | 1 | One-clock strobe: a bit has been recovered |
| bit_o | output | 1 | Recovered bit value (1 = two short halves) |
| err_o | output | 1 | One-clock strobe: timing or pairing violation |

## Verification
There are two kinds of internal state that can go wrong: the pending-half flag with its stored class, and the tick counter. A corrupted pending flag shows up at the very next level change. That change either emits a bit that should not exist, or it fails to emit or flag one, so the result sequence goes out of step with the halves that were driven. A counter that wraps or stops too early turns a stuck or long line into an extra error or a false bit. That error or bit appears two clocks after the edge that ends the long half.

// File: rtl/track_dec_pkg.sv
package track_dec_pkg;
  typedef enum logic [1:0] {
    HALF_BAD  = 2'd0,
    HALF_ONE  = 2'd1,
    HALF_ZERO = 2'd2
  } half_cls_e;
endpackage

// File: rtl/tsd_sync_edge.sv
module tsd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];

  assign edge_o = sync_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/tsd_half_timer.sv
module tsd_half_timer
  import track_dec_pkg::*;
#(
  parameter int ONE_MIN  = 52,
  parameter int ONE_MAX  = 64,
  parameter int ZERO_MIN = 90,
  parameter int ZERO_MAX = 10000
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      edge_i,
  input  logic      tick_i,
  output logic      half_vld_o,
  output half_cls_e half_cls_o
);
  localparam int CNT_W = $clog2(ZERO_MAX + 2);
  localparam logic [CNT_W-1:0] L_SAT   = CNT_W'(ZERO_MAX + 1);
  localparam logic [CNT_W-1:0] L_1_MIN = CNT_W'(ONE_MIN);
  localparam logic [CNT_W-1:0] L_1_MAX = CNT_W'(ONE_MAX);
  localparam logic [CNT_W-1:0] L_0_MIN = CNT_W'(ZERO_MIN);
  localparam logic [CNT_W-1:0] L_0_MAX = CNT_W'(ZERO_MAX);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  half_cls_e        cls_d;

  always_comb begin
    if (cnt_q >= L_1_MIN && cnt_q <= L_1_MAX)      cls_d = HALF_ONE;
    else if (cnt_q >= L_0_MIN && cnt_q <= L_0_MAX) cls_d = HALF_ZERO;
    else                                           cls_d = HALF_BAD;
  end

  // count restarts at each edge; saturation avoids wrap on a stuck line
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q      <= '0;
      armed_q    <= 1'b0;
      half_vld_o <= 1'b0;
      half_cls_o <= HALF_BAD;
    end else begin
      half_vld_o <= edge_i & armed_q;
      if (edge_i) begin
        armed_q    <= 1'b1;
        half_cls_o <= cls_d;
        cnt_q      <= tick_i ? CNT_W'(1) : '0;
      end else if (tick_i && cnt_q != L_SAT) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
endmodule

// File: rtl/tsd_pair_fsm.sv
module tsd_pair_fsm
  import track_dec_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      half_vld_i,
  input  half_cls_e half_cls_i,
  output logic      bit_valid_o,
  output logic      bit_o,
  output logic      err_o
);
  logic      pend_q;
  half_cls_e first_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      first_q     <= HALF_BAD;
      bit_valid_o <= 1'b0;
      bit_o       <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      bit_valid_o <= 1'b0;
      err_o       <= 1'b0;
      if (half_vld_i) begin
        if (half_cls_i == HALF_BAD) begin
          err_o  <= 1'b1;
          pend_q <= 1'b0;
        end else if (!pend_q) begin
          pend_q  <= 1'b1;
          first_q <= half_cls_i;
        end else if (first_q == half_cls_i) begin
          bit_valid_o <= 1'b1;
          bit_o       <= (half_cls_i == HALF_ONE);
          pend_q      <= 1'b0;
        end else begin
          // realign on the current half
          err_o   <= 1'b1;
          first_q <= half_cls_i;
        end
      end
    end
endmodule

// File: rtl/track_bit_decoder.sv
module track_bit_decoder
  import track_dec_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ONE_MIN     = 52,
  parameter int ONE_MAX     = 64,
  parameter int ZERO_MIN    = 90,
  parameter int ZERO_MAX    = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic track_i,
  input  logic tick_us_i,
  output logic bit_valid_o,
  output logic bit_o,
  output logic err_o
);
  logic      track_edge;
  logic      half_vld;
  half_cls_e half_cls;

  tsd_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (track_i),
    .edge_o (track_edge)
  );

  tsd_half_timer #(
    .ONE_MIN (ONE_MIN),
    .ONE_MAX (ONE_MAX),
    .ZERO_MIN(ZERO_MIN),
    .ZERO_MAX(ZERO_MAX)
  ) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .edge_i    (track_edge),
    .tick_i    (tick_us_i),
    .half_vld_o(half_vld),
    .half_cls_o(half_cls)
  );

  tsd_pair_fsm i_pair (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .half_vld_i (half_vld),
    .half_cls_i (half_cls),
    .bit_valid_o(bit_valid_o),
    .bit_o      (bit_o),
    .err_o      (err_o)
  );
endmodule

// File: rtl/track_bit_decoder_chk.sv
module track_bit_decoder_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic track_edge,
  input logic bit_valid_o,
  input logic err_o
);
  assert_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_valid_o && err_o));

  assert_bit_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |=> !bit_valid_o);

  assert_after_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o || err_o) |-> $past(track_edge, 2));

  assert_err_no_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !bit_valid_o);
endmodule

bind track_bit_decoder track_bit_decoder_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .track_edge (track_edge),
  .bit_valid_o(bit_valid_o),
  .err_o      (err_o)
);

// File: tb/test_track_bit_decoder.sv
module test_track_bit_decoder;
  localparam int TDIV = 2;

  typedef struct {
    int    kind;   // 0 = bit 0, 1 = bit 1, 2 = error
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic track = 1'b0;
  logic tick = 1'b0;
  logic bit_valid, bit_val, err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t q[$];
  bit pend = 1'b0;
  int pcls = 0;

  always #2.5 clk = ~clk;

  track_bit_decoder i_track_bit_decoder (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .track_i    (track),
    .tick_us_i  (tick),
    .bit_valid_o(bit_valid),
    .bit_o      (bit_val),
    .err_o      (err)
  );

  initial begin : tick_gen
    int n;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      tick = (n % TDIV == 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int classify(input int d);
    if (d >= 52 && d <= 64) return 1;    // R3 short
    if (d >= 90 && d <= 10000) return 2; // R4 long
    return 0;                            // R6 out of window
  endfunction

  // driver: hold the level d ticks, toggle, push the expected result
  task automatic half(input int d, input string req);
    int c;
    exp_t e;
    repeat (d * TDIV) @(negedge clk);
    track = ~track;
    c = classify(d);
    e.req = req;
    if (c == 0) begin
      e.kind = 2; q.push_back(e); pend = 1'b0;
    end else if (!pend) begin
      pend = 1'b1; pcls = c;
    end else if (pcls == c) begin
      e.kind = (c == 1) ? 1 : 0; q.push_back(e); pend = 1'b0;
    end else begin
      e.kind = 2; q.push_back(e); pcls = c;
    end
  endtask

  // monitor
  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_ni && (bit_valid || err)) begin
        if (q.size() == 0) begin
          check(1'b0, "R9 unexpected strobe", {30'd0, err, bit_valid}, 0);
        end else begin
          e = q.pop_front();
          if (e.kind == 2)
            check(err && !bit_valid, e.req, {30'd0, err, bit_valid}, 2);
          else
            check(bit_valid && !err && bit_val == e.kind[0], e.req,
                  {29'd0, bit_val, err, bit_valid}, 1 + (e.kind << 2));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check(!bit_valid && !err && !bit_val, "R1 in reset", {29'd0, bit_val, err, bit_valid}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check(!bit_valid && !err && !bit_val, "R1 after reset", {29'd0, bit_val, err, bit_valid}, 0);
    track = 1'b1;                         // R9: starts timing only
    half(58, "R5 one pair nominal");
    half(58, "R5 one pair nominal");
    half(52, "R3 low bound");
    half(64, "R3 high bound");
    half(100, "R5 zero pair");
    half(100, "R5 zero pair");
    half(90, "R4 low bound");
    half(10000, "R4 high bound");
    half(51, "R6 below short");
    half(65, "R6 gap low");
    half(89, "R6 gap high");
    half(58, "R6 pending dropped");
    half(70, "R6 error drops pending");
    half(58, "R6 pending dropped");
    half(58, "R6 pending dropped");
    half(58, "R7 mismatch");
    half(100, "R7 mismatch");
    half(100, "R7 realign to zero");
    half(12000, "R8 single error on stuck line");
    half(64, "R2 both polarities");
    half(52, "R2 both polarities");
    repeat (10) @(negedge clk);
    check(q.size() == 0, "R8 no missing results", q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule